// File: doc/BRIEF.md
# Multi-Request Memory Packet Decoder

This block sits on the memory-side end of a serial processor-to-memory link. It takes one message packet at a time as a stream of fixed-width words and turns it into separate memory requests for a local scheduler. A packet opens with a header word. The header names the scheduler the packet is meant for, gives the packet kind (read, write or read-return) and states how many request records follow. Every record in a packet has the same width and the same field layout: an address (or a request identifier, in read-return packets), a granularity code and a thread tag.

Read packets carry records only, so the decoder splits a whole word into several lanes at once and emits them as one batch. A per-lane valid mask covers a final batch that is only partly filled. Write and read-return packets interleave each record with a data payload of `granularity` words (eight bytes per unit). The decoder handles them one record at a time. It spends one cycle working out the payload length, gathers the payload and then emits the record together with its data. A header that is misrouted or malformed, or a record whose granularity is out of range, raises a one-cycle error flag. The decoder then discards the rest of the packet up to its last word.

Both streams use valid/ready handshakes. An input word is taken on a rising edge where `in_valid` and `in_ready` are both high. An output request is taken where `o_valid` and `o_ready` are both high. Once `o_valid` is raised, every output field stays frozen until the request is taken. While a request is waiting, the decoder takes no further read-record words. During the length cycle, and while a finished write or return request waits, `in_ready` is low.

Top module: `mem_pkt_decoder`

## Requirements
- R1: After reset, `o_valid` is 0, `in_ready` is 1 and all four error flags are 0.
- R2: The header's bits [3:0] hold the destination, bits [5:4] the kind and bits [13:6] the record count, and the remaining bits are ignored. A destination that differs from `local_id` raises `err_dest`. No request comes from that packet, and words are dropped up to and including the one marked `in_last`.
- R3: If the destination matches, a kind code of 3 raises `err_kind`. Failing that, a count of 0 raises `err_count`. In both cases the packet is dropped in the same way as in R2. The destination test takes priority over the kind test, and the kind test over the count test.
- R4: Kind 0 is a read. Each following word holds four 16-bit records, with lane i in bits [16i+15:16i]. A record holds the address in bits [9:0], the granularity in [13:10] and the thread tag in [15:14]. Each word becomes one output with `o_kind`=0, lane i in `o_addr`/`o_gran`/`o_tid` slice i, and `o_data` all zero.
- R5: In a read batch, lane i is valid exactly when 4*batch+i is less than the count. The mask on the final batch is therefore 0001, 0011 or 0111 when the count is not a multiple of four.
- R6: Kind 1 is a write. Each record sits in bits [15:0] of its own word, and `gran` data words follow it. The decoder emits one request with mask 0001, the record's fields on lane 0, and `o_kind`=1. Data word k of the request appears at `o_data` bits [64k+63:64k], and the words above the granularity are zero.
- R7: Kind 2 is a read-return and follows the write layout. It emits `o_kind`=2, and its 10-bit request identifier comes out on lane 0 of `o_addr`.
- R8: A write or return record whose granularity is 0 or greater than 8 raises `err_gran`. Nothing is emitted for it, and the rest of the packet is dropped.
- R9: `in_ready` is low in the cycle after a write or return record is accepted. It is also low while a finished write or return request waits on `o_ready`.
- R10: While `o_valid` is high and `o_ready` is low, every output field holds its value and no read-record word is accepted.
- R11: Each error flag pulses for exactly one cycle, the cycle after the offending word is accepted. No two flags are ever high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| local_id | input | 4 | Identifier of this scheduler |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Decoder can take an input word |
| in_data | input | 64 | Packet word |
| in_last | input | 1 | Marks the final word of a packet |
| o_valid | output | 1 | Request output valid |
| o_ready | input | 1 | Downstream takes the request |
| o_kind | output | 2 | 0 read batch, 1 write, 2 read-return |
| o_lane_vld | output | 4 | Per-lane valid mask |
| o_addr | output | 40 | Four 10-bit addresses or request identifiers |
| o_gran | output | 16 | Four 4-bit granularity codes |
| o_tid | output | 8 | Four 2-bit thread tags |
| o_data | output | 512 | Up to eight payload words |
| err_dest | output | 1 | Misrouted packet pulse |
| err_kind | output | 1 | Unknown kind pulse |
| err_count | output | 1 | Zero count pulse |
| err_gran | output | 1 | Bad granularity pulse |

## Verification
The assertions assume that the downstream side obeys the handshake. They also assume that each packet's word count agrees with its header and records, so the decoder is never left waiting on a truncated packet. The stimulus always builds packets that keep to this rule, including the malformed ones: those end with an `in_last` word after a few filler words. Output back-pressure is applied only while complete packets are being sent, so the hold checks see both the stalled and the released cases.

// File: rtl/mpd_pkg.sv
package mpd_pkg;
  typedef enum logic [1:0] {
    PK_READ   = 2'd0,
    PK_WRITE  = 2'd1,
    PK_RETURN = 2'd2,
    PK_RSVD   = 2'd3
  } pkt_kind_e;

  typedef enum logic [2:0] {
    ST_HDR,
    ST_RD,
    ST_WREC,
    ST_WLEN,
    ST_WDAT,
    ST_WOUT,
    ST_DROP
  } dec_state_e;
endpackage

// File: rtl/mpd_hdr_check.sv
module mpd_hdr_check
  import mpd_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int DEST_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic [WORD_W-1:0] hdr_word,
  input  logic [DEST_W-1:0] local_id,
  output pkt_kind_e         kind,
  output logic [CNT_W-1:0]  count,
  output logic              bad_dest,
  output logic              bad_kind,
  output logic              bad_count
);
  localparam int KIND_LSB = DEST_W;
  localparam int CNT_LSB  = DEST_W + 2;
  localparam int RSV_LSB  = CNT_LSB + CNT_W;

  logic [DEST_W-1:0] dest;
  logic              unused_rsvd;

  assign unused_rsvd = ^hdr_word[WORD_W-1:RSV_LSB];

  always_comb begin
    dest      = hdr_word[DEST_W-1:0];
    kind      = pkt_kind_e'(hdr_word[KIND_LSB +: 2]);
    count     = hdr_word[CNT_LSB +: CNT_W];
    // priority: destination, then kind, then count
    bad_dest  = (dest != local_id);
    bad_kind  = !bad_dest && (kind == PK_RSVD);
    bad_count = !bad_dest && !bad_kind && (count == '0);
  end
endmodule

// File: rtl/mpd_lane_split.sv
module mpd_lane_split #(
  parameter int WORD_W = 64,
  parameter int ADDR_W = 10,
  parameter int GRAN_W = 4,
  parameter int TID_W  = 2,
  parameter int CNT_W  = 8,
  parameter int LANES  = WORD_W / (ADDR_W + GRAN_W + TID_W)
) (
  input  logic [WORD_W-1:0]       word,
  input  logic [CNT_W-1:0]        remaining,
  output logic [LANES*ADDR_W-1:0] addr,
  output logic [LANES*GRAN_W-1:0] gran,
  output logic [LANES*TID_W-1:0]  tid,
  output logic [LANES-1:0]        lane_vld
);
  localparam int REC_W = ADDR_W + GRAN_W + TID_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int BASE = i * REC_W;
    assign addr[i*ADDR_W +: ADDR_W] = word[BASE +: ADDR_W];
    assign gran[i*GRAN_W +: GRAN_W] = word[BASE + ADDR_W +: GRAN_W];
    assign tid[i*TID_W +: TID_W]    = word[BASE + ADDR_W + GRAN_W +: TID_W];
    assign lane_vld[i]              = (remaining > CNT_W'(i));
  end
endmodule

// File: rtl/mpd_payload_buf.sv
module mpd_payload_buf #(
  parameter int WORD_W = 64,
  parameter int SLOTS  = 8,
  parameter int IDX_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [WORD_W-1:0]       wr_word,
  output logic [SLOTS*WORD_W-1:0] flat
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [WORD_W-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                slot_q <= '0;
      else if (clear)                            slot_q <= '0;
      else if (wr_en && (wr_idx == IDX_W'(s)))   slot_q <= wr_word;
    end
    assign flat[s*WORD_W +: WORD_W] = slot_q;
  end
endmodule

// File: rtl/mem_pkt_decoder.sv
module mem_pkt_decoder
  import mpd_pkg::*;
#(
  parameter int WORD_W   = 64,
  parameter int ADDR_W   = 10,
  parameter int GRAN_W   = 4,
  parameter int TID_W    = 2,
  parameter int DEST_W   = 4,
  parameter int CNT_W    = 8,
  parameter int MAX_GRAN = 8,
  parameter int LANES    = WORD_W / (ADDR_W + GRAN_W + TID_W)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DEST_W-1:0]         local_id,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [WORD_W-1:0]         in_data,
  input  logic                      in_last,
  output logic                      o_valid,
  input  logic                      o_ready,
  output logic [1:0]                o_kind,
  output logic [LANES-1:0]          o_lane_vld,
  output logic [LANES*ADDR_W-1:0]   o_addr,
  output logic [LANES*GRAN_W-1:0]   o_gran,
  output logic [LANES*TID_W-1:0]    o_tid,
  output logic [MAX_GRAN*WORD_W-1:0] o_data,
  output logic                      err_dest,
  output logic                      err_kind,
  output logic                      err_count,
  output logic                      err_gran
);
  localparam int REC_W = ADDR_W + GRAN_W + TID_W;
  localparam int IDX_W = (MAX_GRAN > 1) ? $clog2(MAX_GRAN) : 1;
  localparam logic [CNT_W-1:0]  LANES_C = CNT_W'(LANES);
  localparam logic [GRAN_W-1:0] GMAX_C  = GRAN_W'(MAX_GRAN);

  // ---------------- control state ----------------
  dec_state_e         state_q;
  logic [CNT_W-1:0]   rem_q;
  pkt_kind_e          kind_q;
  logic [REC_W-1:0]   rec_q;
  logic [IDX_W-1:0]   beat_q;
  logic               e_dest_q, e_kind_q, e_cnt_q, e_gran_q;

  // ---------------- output register ----------------
  logic                    ov_q;
  pkt_kind_e               okind_q;
  logic [LANES-1:0]        omask_q;
  logic [LANES*ADDR_W-1:0] oaddr_q;
  logic [LANES*GRAN_W-1:0] ogran_q;
  logic [LANES*TID_W-1:0]  otid_q;

  // ---------------- header decode ----------------
  pkt_kind_e        h_kind;
  logic [CNT_W-1:0] h_count;
  logic             h_bd, h_bk, h_bc, h_err;

  mpd_hdr_check #(
    .WORD_W(WORD_W), .DEST_W(DEST_W), .CNT_W(CNT_W)
  ) u_hdr (
    .hdr_word (in_data),
    .local_id (local_id),
    .kind     (h_kind),
    .count    (h_count),
    .bad_dest (h_bd),
    .bad_kind (h_bk),
    .bad_count(h_bc)
  );
  assign h_err = h_bd | h_bk | h_bc;

  // ---------------- read batch split ----------------
  logic [LANES*ADDR_W-1:0] sp_addr;
  logic [LANES*GRAN_W-1:0] sp_gran;
  logic [LANES*TID_W-1:0]  sp_tid;
  logic [LANES-1:0]        sp_vld;

  mpd_lane_split #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .GRAN_W(GRAN_W),
    .TID_W(TID_W), .CNT_W(CNT_W), .LANES(LANES)
  ) u_split (
    .word     (in_data),
    .remaining(rem_q),
    .addr     (sp_addr),
    .gran     (sp_gran),
    .tid      (sp_tid),
    .lane_vld (sp_vld)
  );

  // ---------------- serial record fields ----------------
  logic [GRAN_W-1:0] in_gran, cur_gran;
  logic              gran_bad, last_beat;

  assign in_gran   = in_data[ADDR_W +: GRAN_W];
  assign gran_bad  = (in_gran == '0) || (in_gran > GMAX_C);
  assign cur_gran  = rec_q[ADDR_W +: GRAN_W];
  assign last_beat = (GRAN_W'(beat_q) + GRAN_W'(1)) == cur_gran;

  // ---------------- handshake ----------------
  logic out_free, acc, rd_load, wr_load;

  assign out_free = !ov_q || o_ready;

  always_comb begin
    case (state_q)
      ST_HDR:  in_ready = 1'b1;
      ST_RD:   in_ready = out_free;
      ST_WREC: in_ready = out_free;
      ST_WLEN: in_ready = 1'b0;
      ST_WDAT: in_ready = 1'b1;
      ST_WOUT: in_ready = 1'b0;
      ST_DROP: in_ready = 1'b1;
      default: in_ready = 1'b0;
    endcase
  end

  assign acc     = in_valid && in_ready;
  assign rd_load = (state_q == ST_RD) && acc;
  assign wr_load = (state_q == ST_WDAT) && acc && last_beat;

  // ---------------- payload buffer ----------------
  logic [MAX_GRAN*WORD_W-1:0] pay_flat;

  mpd_payload_buf #(
    .WORD_W(WORD_W), .SLOTS(MAX_GRAN), .IDX_W(IDX_W)
  ) u_pay (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (state_q == ST_WLEN),
    .wr_en  ((state_q == ST_WDAT) && acc),
    .wr_idx (beat_q),
    .wr_word(in_data),
    .flat   (pay_flat)
  );

  // ---------------- sequencing ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_HDR;
      rem_q    <= '0;
      kind_q   <= PK_READ;
      rec_q    <= '0;
      beat_q   <= '0;
      e_dest_q <= 1'b0;
      e_kind_q <= 1'b0;
      e_cnt_q  <= 1'b0;
      e_gran_q <= 1'b0;
    end else begin
      e_dest_q <= 1'b0;
      e_kind_q <= 1'b0;
      e_cnt_q  <= 1'b0;
      e_gran_q <= 1'b0;
      case (state_q)
        ST_HDR: if (acc) begin
          if (h_err) begin
            e_dest_q <= h_bd;
            e_kind_q <= h_bk;
            e_cnt_q  <= h_bc;
            state_q  <= in_last ? ST_HDR : ST_DROP;
          end else begin
            rem_q   <= h_count;
            kind_q  <= h_kind;
            state_q <= (h_kind == PK_READ) ? ST_RD : ST_WREC;
          end
        end
        ST_RD: if (acc) begin
          if (rem_q > LANES_C) begin
            rem_q <= rem_q - LANES_C;
          end else begin
            rem_q   <= '0;
            state_q <= ST_HDR;
          end
        end
        ST_WREC: if (acc) begin
          if (gran_bad) begin
            e_gran_q <= 1'b1;
            state_q  <= in_last ? ST_HDR : ST_DROP;
          end else begin
            rec_q   <= in_data[REC_W-1:0];
            state_q <= ST_WLEN;
          end
        end
        ST_WLEN: begin
          beat_q  <= '0;
          state_q <= ST_WDAT;
        end
        ST_WDAT: if (acc) begin
          if (last_beat) begin
            rem_q   <= rem_q - CNT_W'(1);
            state_q <= ST_WOUT;
          end else begin
            beat_q <= beat_q + IDX_W'(1);
          end
        end
        ST_WOUT: if (o_ready) begin
          state_q <= (rem_q == '0) ? ST_HDR : ST_WREC;
        end
        ST_DROP: if (acc && in_last) state_q <= ST_HDR;
        default: state_q <= ST_HDR;
      endcase
    end
  end

  // ---------------- output register ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q    <= 1'b0;
      okind_q <= PK_READ;
      omask_q <= '0;
      oaddr_q <= '0;
      ogran_q <= '0;
      otid_q  <= '0;
    end else if (rd_load) begin
      ov_q    <= 1'b1;
      okind_q <= PK_READ;
      omask_q <= sp_vld;
      oaddr_q <= sp_addr;
      ogran_q <= sp_gran;
      otid_q  <= sp_tid;
    end else if (wr_load) begin
      ov_q    <= 1'b1;
      okind_q <= kind_q;
      omask_q <= LANES'(1);
      oaddr_q <= (LANES*ADDR_W)'(rec_q[ADDR_W-1:0]);
      ogran_q <= (LANES*GRAN_W)'(rec_q[ADDR_W +: GRAN_W]);
      otid_q  <= (LANES*TID_W)'(rec_q[ADDR_W+GRAN_W +: TID_W]);
    end else if (o_ready) begin
      ov_q <= 1'b0;
    end
  end

  assign o_valid    = ov_q;
  assign o_kind     = okind_q;
  assign o_lane_vld = omask_q;
  assign o_addr     = oaddr_q;
  assign o_gran     = ogran_q;
  assign o_tid      = otid_q;
  assign o_data     = (okind_q == PK_READ) ? '0 : pay_flat;
  assign err_dest   = e_dest_q;
  assign err_kind   = e_kind_q;
  assign err_count  = e_cnt_q;
  assign err_gran   = e_gran_q;
endmodule

// File: rtl/mem_pkt_decoder_chk.sv
module mem_pkt_decoder_chk #(
  parameter int LANES    = 4,
  parameter int ADDR_W   = 10,
  parameter int GRAN_W   = 4,
  parameter int MAX_GRAN = 8,
  parameter int DATA_W   = 512
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    o_valid,
  input logic                    o_ready,
  input logic [1:0]              o_kind,
  input logic [LANES-1:0]        o_lane_vld,
  input logic [LANES*ADDR_W-1:0] o_addr,
  input logic [LANES*GRAN_W-1:0] o_gran,
  input logic [DATA_W-1:0]       o_data,
  input logic                    err_dest,
  input logic                    err_kind,
  input logic                    err_count,
  input logic                    err_gran
);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_kind) && $stable(o_lane_vld)
                               && $stable(o_addr) && $stable(o_gran) && $stable(o_data)));

  assert_mask_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> ((o_lane_vld != '0) && ((o_lane_vld & (o_lane_vld + 1'b1)) == '0)));

  assert_single_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && (o_kind != 2'd0)) |-> (o_lane_vld == LANES'(1)));

  assert_gran_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && (o_kind != 2'd0)) |->
      ((o_gran[GRAN_W-1:0] != '0) && (o_gran[GRAN_W-1:0] <= GRAN_W'(MAX_GRAN))));

  assert_kind_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> (o_kind != 2'd3));

  assert_err_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_dest, err_kind, err_count, err_gran}));
endmodule

bind mem_pkt_decoder mem_pkt_decoder_chk #(
  .LANES(LANES), .ADDR_W(ADDR_W), .GRAN_W(GRAN_W),
  .MAX_GRAN(MAX_GRAN), .DATA_W(MAX_GRAN*WORD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .o_valid(o_valid), .o_ready(o_ready),
  .o_kind(o_kind), .o_lane_vld(o_lane_vld), .o_addr(o_addr), .o_gran(o_gran),
  .o_data(o_data), .err_dest(err_dest), .err_kind(err_kind),
  .err_count(err_count), .err_gran(err_gran)
);

// File: tb/mem_pkt_decoder_test.sv
module mem_pkt_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] MY_ID = 4'h5;
  localparam int NVEC = 13;
  // {dest, kind, count, gran, expected error code}
  localparam logic [20:0] VEC [NVEC] = '{
    {4'h5, 2'd0, 8'd4, 4'd0, 3'd0},
    {4'h5, 2'd0, 8'd1, 4'd0, 3'd0},
    {4'h5, 2'd0, 8'd7, 4'd0, 3'd0},
    {4'h5, 2'd0, 8'd9, 4'd0, 3'd0},
    {4'h5, 2'd1, 8'd2, 4'd1, 3'd0},
    {4'h5, 2'd1, 8'd1, 4'd8, 3'd0},
    {4'h5, 2'd2, 8'd2, 4'd4, 3'd0},
    {4'hA, 2'd0, 8'd3, 4'd0, 3'd1},
    {4'h5, 2'd3, 8'd2, 4'd0, 3'd2},
    {4'h5, 2'd0, 8'd0, 4'd0, 3'd3},
    {4'h5, 2'd1, 8'd2, 4'd0, 3'd4},
    {4'h5, 2'd2, 8'd1, 4'd9, 3'd4},
    {4'hA, 2'd3, 8'd0, 4'd0, 3'd1}
  };
  localparam logic [47:0] REC_PAD = 48'hC0FFEE000000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, o_ready = 1'b1;
  logic [63:0] in_data = '0;
  logic in_ready, o_valid, err_dest, err_kind, err_count, err_gran;
  logic [1:0] o_kind;
  logic [3:0] o_lane_vld;
  logic [39:0] o_addr;
  logic [15:0] o_gran;
  logic [7:0] o_tid;
  logic [511:0] o_data;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_pkt_decoder uut (
    .clk(clk), .rst_n(rst_n), .local_id(MY_ID),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .o_valid(o_valid), .o_ready(o_ready), .o_kind(o_kind), .o_lane_vld(o_lane_vld),
    .o_addr(o_addr), .o_gran(o_gran), .o_tid(o_tid), .o_data(o_data),
    .err_dest(err_dest), .err_kind(err_kind), .err_count(err_count), .err_gran(err_gran)
  );

  // ---------------- monitor ----------------
  int cap_n = 0, err_cyc = 0, err_last = 0;
  logic [1:0]   cap_kind [64];
  logic [3:0]   cap_mask [64];
  logic [39:0]  cap_addr [64];
  logic [15:0]  cap_gran [64];
  logic [7:0]   cap_tid  [64];
  logic [511:0] cap_data [64];

  always @(negedge clk) begin
    if (rst_n) begin
      if (o_valid && o_ready && cap_n < 64) begin
        cap_kind[cap_n] = o_kind;
        cap_mask[cap_n] = o_lane_vld;
        cap_addr[cap_n] = o_addr;
        cap_gran[cap_n] = o_gran;
        cap_tid[cap_n]  = o_tid;
        cap_data[cap_n] = o_data;
        cap_n = cap_n + 1;
      end
      if (err_dest | err_kind | err_count | err_gran) begin
        err_cyc = err_cyc + 1;
        err_last = err_dest ? 1 : err_kind ? 2 : err_count ? 3 : 4;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_rec(input int p, input int j, input int g);
    logic [9:0] a;
    logic [1:0] t;
    a = 10'((p * 37 + j * 11) % 1024);
    t = 2'((p + j) % 4);
    return {t, 4'(g), a};
  endfunction

  function automatic logic [63:0] mk_dat(input int p, input int j, input int k);
    return {8'hA5, 8'(p), 16'(j), 16'(k), 16'h3C3C};
  endfunction

  task automatic put(input logic [63:0] w, input bit last);
    bit took;
    in_data = w;
    in_last = last;
    in_valid = 1'b1;
    do begin
      @(negedge clk);
      took = in_ready;
      @(posedge clk);
      #1;
    end while (!took);
    in_valid = 1'b0;
    in_last = 1'b0;
  endtask

  task automatic send_pkt(input int p, input logic [3:0] dest, input logic [1:0] kind,
                          input int count, input int gran, input int err);
    logic [63:0] hdr, word;
    hdr = '0;
    hdr[3:0] = dest;
    hdr[5:4] = kind;
    hdr[13:6] = 8'(count);
    hdr[63:56] = 8'h77;
    put(hdr, 1'b0);
    if (err == 4) begin
      put({REC_PAD, mk_rec(p, 0, gran)}, 1'b0);
      put(mk_dat(p, 0, 0), 1'b0);
      put(mk_dat(p, 0, 1), 1'b1);
    end else if (err != 0) begin
      put(mk_dat(p, 0, 0), 1'b0);
      put(mk_dat(p, 0, 1), 1'b1);
    end else if (kind == 2'd0) begin
      for (int w = 0; w < (count + 3) / 4; w++) begin
        word = '0;
        for (int i = 0; i < 4; i++)
          word[16*i +: 16] = (4*w + i < count) ? mk_rec(p, 4*w + i, (4*w + i) % 8 + 1) : 16'hFFFF;
        put(word, w == (count + 3) / 4 - 1);
      end
    end else begin
      for (int j = 0; j < count; j++) begin
        put({REC_PAD, mk_rec(p, j, gran)}, 1'b0);
        for (int k = 0; k < gran; k++)
          put(mk_dat(p, j, k), (j == count - 1) && (k == gran - 1));
      end
    end
  endtask

  task automatic verify(input int p, input logic [1:0] kind, input int count,
                        input int gran, input int err, input int bn, input int be);
    int n_exp, n_got, idx;
    string tag, etag;
    logic [3:0] emask;
    logic [39:0] ea, aa;
    logic [15:0] eg, ag, r;
    logic [7:0] et, at;
    logic [511:0] ed;
    repeat (4) @(posedge clk);
    #1;
    tag  = (kind == 2'd0) ? "R4" : (kind == 2'd2) ? "R7" : "R6";
    etag = (err == 1) ? "R2" : (err == 4) ? "R8" : "R3";
    n_exp = (err != 0) ? 0 : (kind == 2'd0) ? (count + 3) / 4 : count;
    n_got = cap_n - bn;
    chk(n_got == n_exp, (err != 0) ? etag : tag, "request count", n_got, n_exp);
    if (err != 0) begin
      chk(err_cyc - be == 1, "R11", "error pulse cycles", err_cyc - be, 1);
      chk(err_last == err, etag, "error flag", err_last, err);
    end else begin
      chk(err_cyc - be == 0, "R11", "spurious error cycles", err_cyc - be, 0);
    end
    for (int o = 0; o < n_exp && o < n_got; o++) begin
      idx = bn + o;
      if (idx >= 64) break;
      chk(cap_kind[idx] == kind, tag, "kind", cap_kind[idx], kind);
      if (kind == 2'd0) begin
        emask = '0; ea = '0; eg = '0; et = '0; aa = '0; ag = '0; at = '0;
        for (int i = 0; i < 4; i++) begin
          if (4*o + i < count) begin
            emask[i] = 1'b1;
            r = mk_rec(p, 4*o + i, (4*o + i) % 8 + 1);
            ea[10*i +: 10] = r[9:0];
            eg[4*i +: 4]   = r[13:10];
            et[2*i +: 2]   = r[15:14];
            aa[10*i +: 10] = cap_addr[idx][10*i +: 10];
            ag[4*i +: 4]   = cap_gran[idx][4*i +: 4];
            at[2*i +: 2]   = cap_tid[idx][2*i +: 2];
          end
        end
        chk(cap_mask[idx] == emask, "R5", "lane mask", cap_mask[idx], emask);
        chk(aa == ea, "R4", "lane addresses", aa, ea);
        chk(ag == eg, "R4", "lane granularity", ag, eg);
        chk(at == et, "R4", "lane thread tags", at, et);
        chk(cap_data[idx] == '0, "R4", "read data zero", cap_data[idx], 0);
      end else begin
        r = mk_rec(p, o, gran);
        ed = '0;
        for (int k = 0; k < gran; k++) ed[64*k +: 64] = mk_dat(p, o, k);
        chk(cap_mask[idx] == 4'b0001, "R6", "single lane", cap_mask[idx], 1);
        chk(cap_addr[idx][9:0] == r[9:0], tag, "address or request id", cap_addr[idx][9:0], r[9:0]);
        chk(cap_gran[idx][3:0] == r[13:10], tag, "granularity", cap_gran[idx][3:0], r[13:10]);
        chk(cap_tid[idx][1:0] == r[15:14], tag, "thread tag", cap_tid[idx][1:0], r[15:14]);
        chk(cap_data[idx] == ed, tag, "payload", cap_data[idx], ed);
      end
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    int bn, be;
    logic [69:0] snap;
    logic [15:0] wrec;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(o_valid == 1'b0, "R1", "o_valid in reset", o_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
    chk({err_dest, err_kind, err_count, err_gran} == 4'b0, "R1", "errors in reset",
        {err_dest, err_kind, err_count, err_gran}, 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk);
    #1;

    for (int v = 0; v < NVEC; v++) begin
      bn = cap_n;
      be = err_cyc;
      send_pkt(v, VEC[v][20:17], VEC[v][16:15], int'(VEC[v][14:7]), int'(VEC[v][6:3]), int'(VEC[v][2:0]));
      verify(v, VEC[v][16:15], int'(VEC[v][14:7]), int'(VEC[v][6:3]), int'(VEC[v][2:0]), bn, be);
    end

    // R10: output held and read words refused while downstream stalls
    o_ready = 1'b0;
    bn = cap_n;
    be = err_cyc;
    fork
      send_pkt(20, MY_ID, 2'd0, 8, 0, 0);
      begin
        do @(negedge clk); while (!o_valid);
        snap = {o_kind, o_lane_vld, o_addr, o_gran, o_tid};
        repeat (3) begin
          @(negedge clk);
          chk(o_valid && ({o_kind, o_lane_vld, o_addr, o_gran, o_tid} == snap), "R10",
              "held output", {o_kind, o_lane_vld, o_addr, o_gran, o_tid}, snap);
          chk(!in_ready, "R10", "in_ready while stalled", in_ready, 0);
        end
        @(posedge clk);
        #1 o_ready = 1'b1;
      end
    join
    verify(20, 2'd0, 8, 0, 0, bn, be);

    // R9: length cycle and pending write stall the input
    o_ready = 1'b0;
    bn = cap_n;
    be = err_cyc;
    wrec = mk_rec(21, 0, 2);
    fork
      send_pkt(21, MY_ID, 2'd1, 1, 2, 0);
      begin
        do @(negedge clk); while (!(in_valid && in_ready && in_data == {REC_PAD, wrec}));
        @(negedge clk);
        chk(!in_ready, "R9", "in_ready in length cycle", in_ready, 0);
        do @(negedge clk); while (!o_valid);
        repeat (2) begin
          chk(!in_ready, "R9", "in_ready while write pending", in_ready, 0);
          @(negedge clk);
        end
        @(posedge clk);
        #1 o_ready = 1'b1;
      end
    join
    verify(21, 2'd1, 1, 2, 0, bn, be);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule